// File: doc/BRIEF.md
# Two-Register Instruction Sequencer

This block is a very small instruction-executing core. It walks an instruction pointer through a word-addressed program array and carries out each instruction on a pair of internal registers. The working register takes immediates and results. The spare register is reached only by swapping it with the working register. This makes the swap the primary way to stage an operand for an addition.

The program array is filled through a write port while reset is asserted. After reset is released, each instruction spends one cycle being fetched into an instruction register and one cycle being executed. The instruction pointer, both registers and a halted flag are visible on the ports at all times.

Instruction words are 16 bits wide. Bits [15:12] hold the opcode and bits [11:0] hold the operand.

Top module: `seq2_core`

## Requirements
- R1: While `rst_n` is low, `ip` is 0, both registers are 0 and `halted` is 0.
- R2: A word on `prog_data` is stored at `prog_addr` on a clock edge where `prog_we` is high and `rst_n` is low. A write attempted while `rst_n` is high is ignored and leaves the program unchanged.
- R3: Every instruction takes two cycles. During the fetch cycle no output changes. After a non-jump, non-halt instruction executes, `ip` advances by one and wraps from the last location to 0.
- R4: Opcode 1 (load immediate) copies the 12-bit operand into the working register and leaves the spare register unchanged.
- R5: Opcode 2 (exchange) swaps the working and spare registers.
- R6: Opcode 3 (add) writes the sum of both registers, modulo 2^12, into the working register and leaves the spare register unchanged.
- R7: Opcode 4 (jump) loads `ip` with the low `ADDR_W` bits of the operand and leaves both registers unchanged.
- R8: Opcode 0 (halt) raises `halted` and leaves `ip` on the halt location. From then until reset, `ip`, both registers and `halted` stay constant.
- R9: Opcodes 5 to 15 change no register and advance `ip` like any non-jump instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also opens the program port |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | ADDR_W | Program write address |
| prog_data | input | 4+DATA_W | Program word: opcode in the top 4 bits, operand below |
| ip | output | ADDR_W | Instruction pointer |
| reg_w | output | DATA_W | Working register |
| reg_s | output | DATA_W | Spare register |
| halted | output | 1 | High once a halt has executed |

## Verification
If the internal phase is wrong, an output changes during a fetch cycle or fails to change in an execute cycle. This shows at the ports within one clock. A wrong instruction register or a miscounted pointer puts a wrong value on `reg_w`, `reg_s` or `ip` in the execute cycle of the affected instruction. The wrong value then carries into every later result, so the bench samples after every instruction rather than only at the end of a program. A leaking halt state shows as drift on an output during a long idle window after the halt.

// File: rtl/seq2_pkg.sv
package seq2_pkg;
   localparam int OP_W = 4;

   localparam logic [OP_W-1:0] OPC_HLT = 4'd0;
   localparam logic [OP_W-1:0] OPC_LDI = 4'd1;
   localparam logic [OP_W-1:0] OPC_XCH = 4'd2;
   localparam logic [OP_W-1:0] OPC_ADD = 4'd3;
   localparam logic [OP_W-1:0] OPC_JMP = 4'd4;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_EXEC  = 2'd1,
      PH_HALT  = 2'd2
   } phase_t;
endpackage

// File: rtl/seq2_imem.sv
module seq2_imem #(
   parameter int ADDR_W = 4,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words[waddr] <= wdata;
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/seq2_ctrl.sv
module seq2_ctrl
   import seq2_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [OP_W+DATA_W-1:0] insn,
   output logic [ADDR_W-1:0]      ip,
   output phase_t                 phase,
   output logic [OP_W-1:0]        op,
   output logic [DATA_W-1:0]      arg
);
   logic [OP_W+DATA_W-1:0] ir;

   assign op  = ir[OP_W+DATA_W-1:DATA_W];
   assign arg = ir[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_FETCH;
         ip    <= '0;
         ir    <= '0;
      end else begin
         unique case (phase)
            PH_FETCH: begin
               ir    <= insn;
               phase <= PH_EXEC;
            end
            PH_EXEC: begin
               if (op == OPC_HLT) begin
                  phase <= PH_HALT;
               end else begin
                  phase <= PH_FETCH;
                  if (op == OPC_JMP) ip <= arg[ADDR_W-1:0];
                  else               ip <= ip + 1'b1;
               end
            end
            default: phase <= PH_HALT;
         endcase
      end
   end
endmodule

// File: rtl/seq2_regs.sv
module seq2_regs
   import seq2_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] arg,
   output logic [DATA_W-1:0] reg_w,
   output logic [DATA_W-1:0] reg_s
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_w <= '0;
         reg_s <= '0;
      end else if (exec_en) begin
         case (op)
            OPC_LDI: reg_w <= arg;
            OPC_XCH: begin
               reg_w <= reg_s;
               reg_s <= reg_w;
            end
            OPC_ADD: reg_w <= reg_w + reg_s;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/seq2_core.sv
module seq2_core
   import seq2_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   prog_we,
   input  logic [ADDR_W-1:0]      prog_addr,
   input  logic [OP_W+DATA_W-1:0] prog_data,
   output logic [ADDR_W-1:0]      ip,
   output logic [DATA_W-1:0]      reg_w,
   output logic [DATA_W-1:0]      reg_s,
   output logic                   halted
);
   localparam int WORD_W = OP_W + DATA_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("seq2_core: ADDR_W must lie in 1..10");
   end
   if (DATA_W < ADDR_W) begin : g_bad_data
      $error("seq2_core: DATA_W must be at least ADDR_W so jumps reach every word");
   end

   logic [WORD_W-1:0] insn;
   phase_t            phase;
   logic [OP_W-1:0]   op;
   logic [DATA_W-1:0] arg;
   logic              exec_ph;

   seq2_imem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_imem (
      .clk   (clk),
      .we    (prog_we & ~rst_n),
      .waddr (prog_addr),
      .wdata (prog_data),
      .raddr (ip),
      .rdata (insn)
   );

   seq2_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .insn  (insn),
      .ip    (ip),
      .phase (phase),
      .op    (op),
      .arg   (arg)
   );

   assign exec_ph = (phase == PH_EXEC);
   assign halted  = (phase == PH_HALT);

   seq2_regs #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .exec_en (exec_ph),
      .op      (op),
      .arg     (arg),
      .reg_w   (reg_w),
      .reg_s   (reg_s)
   );
endmodule

// File: rtl/seq2_core_chk.sv
module seq2_core_chk
   import seq2_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_ph,
   input logic [OP_W-1:0]   op,
   input logic [DATA_W-1:0] arg,
   input logic [ADDR_W-1:0] ip,
   input logic [DATA_W-1:0] reg_w,
   input logic [DATA_W-1:0] reg_s,
   input logic              halted
);
   a_r1_reset_ip: assert property (@(posedge clk) !rst_n |-> ip == '0 && !halted);

   a_r3_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_ph |=> $stable(ip) && $stable(reg_w) && $stable(reg_s));

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      exec_ph && op != OPC_JMP && op != OPC_HLT |=> ip == ADDR_W'($past(ip) + 1'b1));

   a_r4_ldi: assert property (@(posedge clk) disable iff (!rst_n)
      exec_ph && op == OPC_LDI |=> reg_w == $past(arg) && $stable(reg_s));

   a_r5_xch: assert property (@(posedge clk) disable iff (!rst_n)
      exec_ph && op == OPC_XCH |=> reg_w == $past(reg_s) && reg_s == $past(reg_w));

   a_r6_add: assert property (@(posedge clk) disable iff (!rst_n)
      exec_ph && op == OPC_ADD |=> reg_w == DATA_W'($past(reg_w) + $past(reg_s)) && $stable(reg_s));

   a_r7_jmp: assert property (@(posedge clk) disable iff (!rst_n)
      exec_ph && op == OPC_JMP |=> ip == $past(arg[ADDR_W-1:0]) && $stable(reg_w));

   a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(ip) && $stable(reg_w) && $stable(reg_s));

   a_r9_undef: assert property (@(posedge clk) disable iff (!rst_n)
      exec_ph && op > OPC_JMP |=> $stable(reg_w) && $stable(reg_s));
endmodule

bind seq2_core seq2_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .exec_ph (exec_ph),
   .op      (op),
   .arg     (arg),
   .ip      (ip),
   .reg_w   (reg_w),
   .reg_s   (reg_s),
   .halted  (halted)
);

// File: tb/test_seq2_core.sv
module test_seq2_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_we = 1'b0;
   logic [3:0]  prog_addr = '0;
   logic [15:0] prog_data = '0;
   logic [3:0]  ip;
   logic [11:0] reg_w, reg_s;
   logic        halted;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [15:0] prog [16];

   seq2_core i_seq2_core (
      .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_data(prog_data), .ip(ip), .reg_w(reg_w), .reg_s(reg_s), .halted(halted)
   );

   always #10 clk = ~clk;

   function automatic logic [15:0] enc(input logic [3:0] opc, input logic [11:0] val);
      return {opc, val};
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag, input int e_ip, input int e_w,
                              input int e_s, input int e_h);
      check({tag, " ip"}, ip, e_ip);
      check({tag, " reg_w"}, reg_w, e_w);
      check({tag, " reg_s"}, reg_s, e_s);
      check({tag, " halted"}, halted, e_h);
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 16; i++) prog[i] = enc(4'd0, 12'd0);
   endtask

   // holds reset, writes all sixteen words, releases reset on a falling edge
   task automatic load_and_start();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) begin
         prog_we = 1'b1; prog_addr = 4'(i); prog_data = prog[i];
         @(negedge clk);
      end
      prog_we = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_sequence();
      clear_prog();
      prog[0] = enc(4'd1, 12'd10);
      prog[1] = enc(4'd2, 12'd0);
      prog[2] = enc(4'd1, 12'd20);
      prog[3] = enc(4'd3, 12'd0);
      prog[4] = enc(4'd4, 12'd1);
      load_and_start();
      step(1); check_state("R3 fetch cycle quiet", 0, 0, 0, 0);
      step(1); check_state("R4 load", 1, 10, 0, 0);
      step(2); check_state("R5 swap", 2, 0, 10, 0);
      step(2); check_state("R4 load keeps spare", 3, 20, 10, 0);
      step(2); check_state("R6 add", 4, 30, 10, 0);
      step(1); check_state("R3 fetch before jump", 4, 30, 10, 0);
      step(1); check_state("R7 jump", 1, 30, 10, 0);
      step(2); check_state("R5 swap after jump", 2, 10, 30, 0);
   endtask

   task automatic t_add_wrap();
      clear_prog();
      prog[0] = enc(4'd1, 12'hFFF);
      prog[1] = enc(4'd2, 12'd0);
      prog[2] = enc(4'd1, 12'd2);
      prog[3] = enc(4'd3, 12'd0);
      load_and_start();
      step(8); check_state("R6 add wraps", 4, 12'h001, 12'hFFF, 0);
   endtask

   task automatic t_halt_and_port();
      clear_prog();
      prog[0] = enc(4'd1, 12'd7);
      prog[1] = enc(4'd0, 12'd0);
      prog[2] = enc(4'd1, 12'd9);
      load_and_start();
      step(4); check_state("R8 halt", 1, 7, 0, 1);
      step(30); check_state("R8 halt hold", 1, 7, 0, 1);
      // write while running is ignored
      prog_we = 1'b1; prog_addr = 4'd0; prog_data = enc(4'd1, 12'h055);
      step(1);
      prog_we = 1'b0;
      check_state("R2 write while running no effect", 1, 7, 0, 1);
      rst_n = 1'b0;
      step(1); check_state("R1 reset clears", 0, 0, 0, 0);
      rst_n = 1'b1;
      step(2); check_state("R2 ignored write left word 0", 1, 7, 0, 0);
   endtask

   task automatic t_undefined();
      clear_prog();
      prog[0] = enc(4'd1, 12'd3);
      prog[1] = enc(4'd9, 12'h123);
      prog[2] = enc(4'd15, 12'hABC);
      prog[3] = enc(4'd2, 12'd0);
      load_and_start();
      step(4); check_state("R9 opcode 9", 2, 3, 0, 0);
      step(2); check_state("R9 opcode 15", 3, 3, 0, 0);
      step(2); check_state("R9 then swap", 4, 0, 3, 0);
   endtask

   task automatic t_ip_wrap();
      clear_prog();
      prog[0]  = enc(4'd4, 12'h3FE);   // low four bits select location 14
      prog[14] = enc(4'd1, 12'h0AB);
      prog[15] = enc(4'd2, 12'd0);
      load_and_start();
      step(2); check_state("R7 jump uses low bits", 14, 0, 0, 0);
      step(2); check_state("R4 load at 14", 15, 12'h0AB, 0, 0);
      step(2); check_state("R3 ip wraps", 0, 0, 12'h0AB, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      step(2);
      check_state("R1 reset state", 0, 0, 0, 0);
      t_sequence();
      t_add_wrap();
      t_halt_and_port();
      t_undefined();
      t_ip_wrap();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 50000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule